// File: doc/BRIEF.md
# Two-Sample Look-Ahead First-Order Recursive Filter

This block is a first-order recursive (IIR) filter, y[n] = x[n] + A*y[n-1], unrolled so that every clock cycle takes two input samples and produces two filtered samples. Each accepted pair holds an older sample and a newer sample. The block returns the matching older and newer outputs one cycle later, together with a valid strobe.

The newer output does not wait for the older one. It is computed in look-ahead form, y[n] = x[n] + A*x[n-1] + A²*y[n-2]. The squared coefficient is folded into a constant at elaboration. The only state the filter carries between pairs is the newer output of the last accepted pair. The recurrence through that state is therefore one multiply followed by two adds.

Both lanes keep their products at full width. Each lane rounds once, half up, back to the sample width and then saturates. The coefficient is a parameter, signed, with COEF_W-2 fraction bits. The default is 0.75.

Top module: `iir_pair_lookahead`

## Requirements
- R1: After an accepted pair, yOld = sat(round((xOld·2^F + A·S) / 2^F)). Here F = COEF_W-2, A is the coefficient code and S is the filter state. Rounding adds 2^(F-1) and then shifts arithmetically right by F.
- R2: After an accepted pair, yNew = sat(round((xNew·2^(2F) + A·xOld·2^F + A²·S) / 2^(2F))). A² is the exact square of the coefficient code, formed at elaboration. Rounding adds 2^(2F-1) and then shifts right by 2F. When nothing saturates, yNew is within 1 LSB of a serial filter that feeds the rounded yOld back through A.
- R3: Both outputs saturate to the range -2^(DATA_W-1) .. 2^(DATA_W-1)-1 instead of wrapping.
- R4: outValid is high in exactly the cycle after each cycle in which inValid was sampled high. It is low in every other cycle.
- R5: In a cycle with inValid low, the inputs are ignored. yOld, yNew and the filter state keep their values.
- R6: The filter state is the newer output of the last accepted pair, and it serves as y[n-2] for the next pair. Reset sets the state, yOld, yNew and outValid to zero.
- R7: The coefficient is a signed COEF_W-bit code with COEF_W-2 fraction bits (12288 means 0.75). Inputs and outputs are signed two's complement, DATA_W bits wide, with integer scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A sample pair is presented this cycle |
| xOld | input | DATA_W | Older sample of the pair, x[n-1] |
| xNew | input | DATA_W | Newer sample of the pair, x[n] |
| outValid | output | 1 | The output pair is fresh this cycle |
| yOld | output | DATA_W | Older filtered sample, y[n-1] |
| yNew | output | DATA_W | Newer filtered sample, y[n]; also the filter state |

## Verification
The newer output register is the only state. A corrupted state therefore shows at the ports in two places. First, yNew is wrong in the cycle it is written. Second, both outputs of the very next accepted pair are wrong, because yOld depends on the state through A and yNew through A². A state that moves during idle cycles shows as a change on the held outputs before the next valid pair arrives. It also shows as a mismatch on that pair against a model that did not advance.

// File: rtl/iir2_pkg.sv
package iir2_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic loadPair;   // capture the computed pair and advance the state
  } ctrlStrobes_t;
endpackage

// File: rtl/iir2_round_sat.sv
// Round half up by SHIFT bits, then saturate to OUT_W bits.
module iir2_round_sat #(
  parameter int IN_W  = 50,
  parameter int SHIFT = 14,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  acc,
  output logic signed [OUT_W-1:0] q
);
  localparam int HI_W = IN_W - OUT_W + 2;
  localparam logic signed [IN_W:0] BIAS =
    {{(IN_W-SHIFT+1){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};

  logic signed [IN_W:0] biased;
  logic signed [IN_W:0] shifted;
  logic [HI_W-1:0]      hiBits;

  always_comb begin
    biased  = {acc[IN_W-1], acc} + BIAS;
    shifted = biased >>> SHIFT;
    hiBits  = shifted[IN_W:OUT_W-1];
    if ((&hiBits) || !(|hiBits)) begin
      q = shifted[OUT_W-1:0];
    end else if (shifted[IN_W]) begin
      q = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      q = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/iir2_ctrl.sv
module iir2_ctrl
  import iir2_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  always_comb strobes.loadPair = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R4: an accepted pair yields a valid output in the next cycle
  p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R4: no output strobe without an accepted pair
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/iir2_datapath.sv
module iir2_datapath
  import iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int COEF_A = 12288
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic signed [DATA_W-1:0] xOld,
  input  logic signed [DATA_W-1:0] xNew,
  output logic signed [DATA_W-1:0] yOld,
  output logic signed [DATA_W-1:0] yNew
);
  localparam int FRAC  = COEF_W - 2;
  localparam int ACC_W = DATA_W + 2*COEF_W + 2;
  localparam logic signed [COEF_W-1:0]   A_Q  = COEF_W'(COEF_A);
  localparam logic signed [2*COEF_W-1:0] A_SQ =
    (2*COEF_W)'(A_Q) * (2*COEF_W)'(A_Q);

  // yNew doubles as the filter state, y[n-2] for the next pair (R6).
  logic signed [ACC_W-1:0] aExt, aSqExt, stateExt, xOldExt, xNewExt;
  logic signed [ACC_W-1:0] accOld, accNew;
  logic signed [DATA_W-1:0] yOldNext, yNewNext;

  always_comb begin
    aExt     = ACC_W'(A_Q);
    aSqExt   = ACC_W'(A_SQ);
    stateExt = ACC_W'(yNew);
    xOldExt  = ACC_W'(xOld);
    xNewExt  = ACC_W'(xNew);
    // Older lane: single-step recurrence (R1).
    accOld = (xOldExt <<< FRAC) + aExt * stateExt;
    // Newer lane: look-ahead, fed from the state through A^2 (R2).
    accNew = (xNewExt <<< (2*FRAC)) + ((aExt * xOldExt) <<< FRAC)
           + aSqExt * stateExt;
  end

  iir2_round_sat #(.IN_W(ACC_W), .SHIFT(FRAC), .OUT_W(DATA_W)) uRoundOld (
    .acc(accOld), .q(yOldNext));
  iir2_round_sat #(.IN_W(ACC_W), .SHIFT(2*FRAC), .OUT_W(DATA_W)) uRoundNew (
    .acc(accNew), .q(yNewNext));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yOld <= '0;
      yNew <= '0;
    end else if (strobes.loadPair) begin
      yOld <= yOldNext;
      yNew <= yNewNext;
    end
  end

  // R5: state and outputs hold while no pair is accepted
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadPair |=> ($stable(yOld) && $stable(yNew)));
  // R2: zero input with zero state keeps both lanes at zero
  p_zero_rest_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadPair && xOld == '0 && xNew == '0 && yNew == '0)
      |=> (yOld == '0 && yNew == '0));
endmodule

// File: rtl/iir_pair_lookahead.sv
module iir_pair_lookahead
  import iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int COEF_A = 12288
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] xOld,
  input  logic signed [DATA_W-1:0] xNew,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] yOld,
  output logic signed [DATA_W-1:0] yNew
);
  ctrlStrobes_t strobes;

  iir2_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid));

  iir2_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_A(COEF_A)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .xOld(xOld), .xNew(xNew), .yOld(yOld), .yNew(yNew));
endmodule

// File: tb/tb_iir_pair_lookahead.sv
module tb_iir_pair_lookahead;
  localparam int     DW = 16;
  localparam int     FR = 14;
  localparam longint A  = 12288;   // R7: 0.75 with 14 fraction bits
  localparam longint MAXV = 32767;
  localparam longint MINV = -32768;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] xOld = '0, xNew = '0;
  logic outValid;
  logic signed [DW-1:0] yOld, yNew;

  iir_pair_lookahead dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .xOld(xOld), .xNew(xNew),
    .outValid(outValid), .yOld(yOld), .yNew(yNew));

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  longint modelY = 0;

  longint expOldQ[$];
  longint expNewQ[$];
  longint serialQ[$];
  bit     serialOkQ[$];

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint rnd(input longint acc, input int sh);
    return (acc + (64'sd1 <<< (sh-1))) >>> sh;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: compute expected pair, queue it, present the pair.
  task automatic sendPair(input longint x1, input longint x0);
    longint o, n, s;
    o = sat(rnd(x1 * (64'sd1 <<< FR) + A * modelY, FR));
    n = sat(rnd(x0 * (64'sd1 <<< (2*FR)) + A * x1 * (64'sd1 <<< FR)
                + A * A * modelY, 2*FR));
    s = sat(rnd(x0 * (64'sd1 <<< FR) + A * o, FR));
    expOldQ.push_back(o);
    expNewQ.push_back(n);
    serialQ.push_back(s);
    serialOkQ.push_back(!(o == MAXV || o == MINV || n == MAXV || n == MINV ||
                          s == MAXV || s == MINV));
    modelY = n;
    @(posedge clk); #1;
    inValid = 1'b1;
    xOld = DW'(x1);
    xNew = DW'(x0);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      inValid = 1'b0;
      xOld = DW'($urandom);   // garbage that must be ignored (R5)
      xNew = DW'($urandom);
    end
  endtask

  // Monitor: scoreboard compare away from the active edge.
  bit lastInValid = 1'b0;
  longint holdOld = 0, holdNew = 0;
  always @(negedge clk) begin
    if (started) begin
      check(outValid == lastInValid, "R4", "outValid vs prior inValid",
            longint'(outValid), longint'(lastInValid));
      if (outValid) begin
        if (expOldQ.size() == 0) begin
          check(1'b0, "R4", "output without pending pair", 1, 0);
        end else begin
          longint eo, en, es;
          bit sok;
          eo = expOldQ.pop_front();
          en = expNewQ.pop_front();
          es = serialQ.pop_front();
          sok = serialOkQ.pop_front();
          check(longint'(yOld) == eo, (eo == MAXV || eo == MINV) ? "R3" : "R1",
                "yOld", longint'(yOld), eo);
          check(longint'(yNew) == en, (en == MAXV || en == MINV) ? "R3" : "R2",
                "yNew", longint'(yNew), en);
          if (sok) begin
            longint d;
            d = longint'(yNew) - es;
            check(d <= 1 && d >= -1, "R2", "yNew vs serial model",
                  longint'(yNew), es);
          end
        end
        holdOld = longint'(yOld);
        holdNew = longint'(yNew);
      end else begin
        check(longint'(yOld) == holdOld, "R5", "yOld held while idle",
              longint'(yOld), holdOld);
        check(longint'(yNew) == holdNew, "R5", "yNew/state held while idle",
              longint'(yNew), holdNew);
      end
      lastInValid = inValid;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R6: reset state
    check(outValid == 1'b0, "R6", "outValid after reset", longint'(outValid), 0);
    check(yOld == '0, "R6", "yOld after reset", longint'(yOld), 0);
    check(yNew == '0, "R6", "yNew after reset", longint'(yNew), 0);
    lastInValid = inValid;
    started = 1'b1;

    // Impulse and decay from zero state (R1, R2, R6)
    sendPair(8000, 0);
    for (int i = 0; i < 4; i++) sendPair(0, 0);
    idle(3);
    // Step input
    for (int i = 0; i < 6; i++) sendPair(4000, 4000);
    idle(1);
    // Negative values, alternating signs
    for (int i = 0; i < 4; i++) sendPair(-12000, 3000);
    idle(2);
    // Positive and negative saturation (R3)
    for (int i = 0; i < 5; i++) sendPair(32767, 32767);
    idle(2);
    for (int i = 0; i < 6; i++) sendPair(-32768, -32768);
    idle(2);
    // Random pairs with random gaps; the gaps exercise R5
    for (int i = 0; i < 300; i++) begin
      longint a, b;
      a = longint'($signed(16'($urandom)));
      b = longint'($signed(16'($urandom)));
      if (i % 3 == 0) begin
        a = a / 8;
        b = b / 8;
      end
      sendPair(a, b);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(expOldQ.size() == 0, "R4", "pairs left without output",
          longint'(expOldQ.size()), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule